// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block maps a 13-bit virtual word address onto a 12-bit physical word address. The virtual space is split into eight 1K-word pages and the physical space into four 1K-word blocks. A small register table, one entry per virtual page, stores the physical block that currently holds the page and a flag that says whether the page is resident. The top three virtual bits select the entry. The low ten bits give the word offset inside the page and are copied unchanged into the physical address.

A requester raises a strobe with a virtual address. One clock later the block reports one of two outcomes. On a hit it gives the physical address. On a page fault the entry's resident flag was clear, and no address is given. A separate write port lets an outside controller service faults. It can load a page by writing its block number with the flag set, or evict a page by writing the flag clear. Bringing pages in from backing store and choosing which page to evict are left to that controller.

Top module: `page_xlate`

## Requirements
- R1: The virtual page is `req_vaddr[12:10]` and the word offset is `req_vaddr[9:0]`. On a hit, `rsp_paddr[9:0]` equals the offset of the request.
- R2: On a hit, `rsp_paddr[11:10]` equals the block number stored in the entry of the requested page.
- R3: When the requested page's resident flag is 0, the response has `rsp_fault`=1, `rsp_hit`=0 and `rsp_paddr`=0.
- R4: A request is answered in the clock after the one in which `req_valid` is high. In any cycle with no answer due, `rsp_hit`, `rsp_fault` and `rsp_paddr` are all 0.
- R5: A write with `tbl_we`=1 and `tbl_present`=1 stores `tbl_block` for page `tbl_page`. Later lookups of that page hit on the new block.
- R6: A write with `tbl_present`=0 evicts page `tbl_page`. Later lookups of that page fault.
- R7: Reset (synchronous, active high) clears every resident flag and every output. After reset, every lookup faults until pages are loaded.
- R8: A lookup and a table write to the same page in the same cycle answer from the entry as it was before the write.
- R9: Every request gets exactly one of `rsp_hit` or `rsp_fault`, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 13 | Virtual word address |
| tbl_we | input | 1 | Table write enable |
| tbl_page | input | 3 | Page whose entry is written |
| tbl_block | input | 2 | Physical block number to store |
| tbl_present | input | 1 | Resident flag to store |
| rsp_hit | output | 1 | Translation succeeded (one cycle after request) |
| rsp_fault | output | 1 | Requested page not resident |
| rsp_paddr | output | 12 | Physical word address on hit, else 0 |

## Verification
The assertions assume that `req_valid`, `tbl_we` and their data are known values at every clock edge outside reset. They also assume that a block number is used only after a write with the flag set has stored it. The block storage has no reset, so a lookup that hits always reads a written value. The bench drives every input each cycle from a seeded generator, including fields nobody looks at. It writes the table only through the write port, so its model and the design start from the same empty table after reset. The directed cases put a write and a lookup on the same page in the same cycle, evict pages that are resident, and reload pages onto blocks that other pages already map to.

// File: rtl/xl_pkg.sv
package xl_pkg;
  // default geometry: 8 pages of 1K words onto 4 blocks
  localparam int unsigned XL_PAGE_W = 3;
  localparam int unsigned XL_LINE_W = 10;
  localparam int unsigned XL_BLK_W  = 2;

  // outcome of one lookup
  typedef enum logic [1:0] {
    XL_NONE  = 2'd0,
    XL_HIT   = 2'd1,
    XL_FAULT = 2'd2
  } xl_kind_e;
endpackage

// File: rtl/xl_ptable.sv
module xl_ptable #(
  parameter int unsigned PAGE_W = 3,
  parameter int unsigned BLK_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic [BLK_W-1:0]  wr_block,
  input  logic              wr_pres,
  input  logic [PAGE_W-1:0] rd_page,
  output logic [BLK_W-1:0]  rd_block,
  output logic              rd_pres
);
  localparam int unsigned N_PAGES = 1 << PAGE_W;

  // block numbers: plain storage with no reset, so it maps to distributed RAM
  logic [BLK_W-1:0]   blk_mem [N_PAGES];
  // resident flags: registers, cleared by reset
  logic [N_PAGES-1:0] pres_q;

  always_ff @(posedge clk) begin
    if (wr_en) blk_mem[wr_page] <= wr_block;
  end

  always_ff @(posedge clk) begin
    if (rst)        pres_q <= '0;
    else if (wr_en) pres_q[wr_page] <= wr_pres;
  end

  // asynchronous read returns the contents from before this edge's write
  assign rd_block = blk_mem[rd_page];
  assign rd_pres  = pres_q[rd_page];

  // R7
  pres_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pres_q == '0));

  // R5
  pres_written_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !$past(rst)) |-> (pres_q[$past(wr_page)] == $past(wr_pres)));

  // R5
  blk_written_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !$past(rst)) |-> (blk_mem[$past(wr_page)] == $past(wr_block)));
endmodule

// File: rtl/xl_lookup.sv
module xl_lookup
  import xl_pkg::*;
#(
  parameter int unsigned PAGE_W = 3,
  parameter int unsigned LINE_W = 10,
  parameter int unsigned BLK_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [LINE_W-1:0]       req_line,
  input  logic [BLK_W-1:0]        ent_block,
  input  logic                    ent_pres,
  output logic                    hit,
  output logic                    fault,
  output logic [BLK_W+LINE_W-1:0] paddr
);
  localparam int unsigned PA_W = BLK_W + LINE_W;

  xl_kind_e          kind_d, kind_q;
  logic [PA_W-1:0]   pa_d, pa_q;

  always_comb begin
    kind_d = XL_NONE;
    pa_d   = '0;
    if (req_valid) begin
      if (ent_pres) begin
        kind_d = XL_HIT;
        pa_d   = {ent_block, req_line};
      end else begin
        kind_d = XL_FAULT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= XL_NONE;
      pa_q   <= '0;
    end else begin
      kind_q <= kind_d;
      pa_q   <= pa_d;
    end
  end

  assign hit   = (kind_q == XL_HIT);
  assign fault = (kind_q == XL_FAULT);
  assign paddr = pa_q;

  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    !(hit && fault));

  // R9
  req_answered_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid) && !$past(rst)) |-> (hit || fault));

  // R4
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (hit || fault) |-> $past(req_valid));

  // R1
  line_pass_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (paddr[LINE_W-1:0] == $past(req_line)));

  // R3
  fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (paddr == '0));
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import xl_pkg::*;
#(
  parameter int unsigned PAGE_W = XL_PAGE_W,
  parameter int unsigned LINE_W = XL_LINE_W,
  parameter int unsigned BLK_W  = XL_BLK_W,
  localparam int unsigned VA_W  = PAGE_W + LINE_W,
  localparam int unsigned PA_W  = BLK_W + LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              tbl_we,
  input  logic [PAGE_W-1:0] tbl_page,
  input  logic [BLK_W-1:0]  tbl_block,
  input  logic              tbl_present,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr
);
  logic [PAGE_W-1:0] vpage;
  logic [LINE_W-1:0] vline;
  logic [BLK_W-1:0]  ent_block;
  logic              ent_pres;

  assign vpage = req_vaddr[VA_W-1:LINE_W];
  assign vline = req_vaddr[LINE_W-1:0];

  xl_ptable #(
    .PAGE_W (PAGE_W),
    .BLK_W  (BLK_W)
  ) u_table (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (tbl_we),
    .wr_page  (tbl_page),
    .wr_block (tbl_block),
    .wr_pres  (tbl_present),
    .rd_page  (vpage),
    .rd_block (ent_block),
    .rd_pres  (ent_pres)
  );

  xl_lookup #(
    .PAGE_W (PAGE_W),
    .LINE_W (LINE_W),
    .BLK_W  (BLK_W)
  ) u_look (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_line  (vline),
    .ent_block (ent_block),
    .ent_pres  (ent_pres),
    .hit       (rsp_hit),
    .fault     (rsp_fault),
    .paddr     (rsp_paddr)
  );
endmodule

// File: tb/sim_page_xlate.sv
`timescale 1ns/1ps
module sim_page_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [12:0] req_vaddr = '0;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_page = '0;
  logic [1:0]  tbl_block = '0;
  logic        tbl_present = 1'b0;
  logic        rsp_hit, rsp_fault;
  logic [11:0] rsp_paddr;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [1:0] m_blk [8];
  logic [7:0] m_pres = '0;

  always #4 clk = ~clk;

  page_xlate u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .tbl_we(tbl_we), .tbl_page(tbl_page), .tbl_block(tbl_block),
    .tbl_present(tbl_present), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr)
  );

  // expected {hit, fault, paddr} computed from the model table
  function automatic logic [13:0] expect_rsp(input logic rq, input logic [12:0] va);
    logic [2:0] pg;
    pg = va[12:10];
    if (!rq)          return 14'd0;
    if (m_pres[pg])   return {1'b1, 1'b0, m_blk[pg], va[9:0]};
    return {1'b0, 1'b1, 12'd0};
  endfunction

  // called at a falling edge: drive, advance one cycle, check
  task automatic step(input logic rq, input logic [12:0] va,
                      input logic we, input logic [2:0] pg,
                      input logic [1:0] bk, input logic pr,
                      input string tag);
    logic [13:0] exp_v;
    logic [13:0] got;
    req_valid = rq; req_vaddr = va;
    tbl_we = we; tbl_page = pg; tbl_block = bk; tbl_present = pr;
    exp_v = expect_rsp(rq, va);           // R8: old table contents
    if (we) begin
      m_blk[pg]  = bk;
      m_pres[pg] = pr;
    end
    @(negedge clk);
    got = {rsp_hit, rsp_fault, rsp_paddr};
    checks++;
    if (got !== exp_v) begin
      bad++;
      $display("FAIL %s: got hit=%b fault=%b paddr=%h, expected hit=%b fault=%b paddr=%h",
               tag, got[13], got[12], got[11:0], exp_v[13], exp_v[12], exp_v[11:0]);
    end
  endtask

  task automatic idle(input string tag);
    step(1'b0, 13'h1fff, 1'b0, 3'd0, 2'd0, 1'b0, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R7: outputs zero while reset is still applied after a request attempt
    req_valid = 1'b1;
    @(negedge clk);
    checks++;
    if ({rsp_hit, rsp_fault, rsp_paddr} !== 14'd0) begin
      bad++;
      $display("FAIL R7: reset outputs got %b%b %h expected 00 000", rsp_hit, rsp_fault, rsp_paddr);
    end
    rst = 1'b0;
    req_valid = 1'b0;
    idle("R4 idle after reset");
    // R7: every page faults after reset
    for (int p = 0; p < 8; p++) step(1'b1, {p[2:0], 10'h155}, 1'b0, 3'd0, 2'd0, 1'b0, "R7 fault after reset");
    // R5 load pages, R1 R2 translate
    step(1'b0, 13'd0, 1'b1, 3'd5, 2'd2, 1'b1, "R5 load");
    step(1'b1, {3'd5, 10'h153}, 1'b0, 3'd0, 2'd0, 1'b0, "R2 hit block");
    step(1'b1, {3'd5, 10'h3ff}, 1'b0, 3'd0, 2'd0, 1'b0, "R1 top offset");
    step(1'b1, {3'd5, 10'h000}, 1'b0, 3'd0, 2'd0, 1'b0, "R1 zero offset");
    // R8: same-cycle load and lookup sees old (absent) entry, then hit
    step(1'b1, {3'd3, 10'h0aa}, 1'b1, 3'd3, 2'd1, 1'b1, "R8 load bypass");
    step(1'b1, {3'd3, 10'h0aa}, 1'b0, 3'd0, 2'd0, 1'b0, "R5 after load");
    // R8: same-cycle evict sees old (present) entry, then fault
    step(1'b1, {3'd5, 10'h2c1}, 1'b1, 3'd5, 2'd0, 1'b0, "R8 evict bypass");
    step(1'b1, {3'd5, 10'h2c1}, 1'b0, 3'd0, 2'd0, 1'b0, "R6 after evict");
    // R5: two pages sharing a block, and a reload onto a new block
    step(1'b0, 13'd0, 1'b1, 3'd7, 2'd1, 1'b1, "R5 shared block");
    step(1'b1, {3'd7, 10'h001}, 1'b0, 3'd0, 2'd0, 1'b0, "R2 shared block");
    step(1'b0, 13'd0, 1'b1, 3'd3, 2'd3, 1'b1, "R5 reload");
    step(1'b1, {3'd3, 10'h200}, 1'b0, 3'd0, 2'd0, 1'b0, "R2 reload");
    idle("R4 quiet");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic rq, we, pr;
      logic [12:0] va;
      string tag;
      rq = ($urandom % 4) != 0;
      we = ($urandom % 3) == 0;
      pr = ($urandom % 4) != 0;
      va = 13'($urandom);
      if (!rq)                tag = "R4 random idle";
      else if (m_pres[va[12:10]]) tag = "R2 R1 random hit";
      else                    tag = "R3 random fault";
      step(rq, va, we, 3'($urandom), 2'($urandom), pr, tag);
    end
    // R7: reset mid-run clears the table
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_pres = '0;
    for (int p = 0; p < 8; p++) step(1'b1, {p[2:0], 10'h3c3}, 1'b0, 3'd0, 2'd0, 1'b0, "R7 fault after second reset");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: got no finish expected finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule